// File: doc/BRIEF.md
# Three-Bank Cascaded Interrupt Controller

This block gathers twenty-four level-sensitive request lines into three banks of eight. Each bank acts as a subordinate controller with its own mask register and command port. A combining stage ranks the banks, presents one winning line to the processor as a vector, and tracks which bank currently has a line being serviced. Software programs the block over a byte-wide write bus and can read back the mask and configuration registers on the same address lines.

A line is taken when the processor pulses the acknowledge input. From that moment its bank is frozen. Retiring the line takes two specific end-of-interrupt commands: one to the bank's command port naming the local line, and one to the combining port naming that bank's cascade input. The two may arrive in either order. The vector encodes the global line number so that software can recover it with a subtract and a shift.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all three bank masks read 0xFF, the configuration register reads 0x00 and intOut is low.
- R2: A write to 0x537, 0x53B or 0x53D replaces all eight mask bits of bank 0, 1 or 2 respectively, and the value reads back from the same address. A mask bit of 1 disables its line.
- R3: No vector is presented unless the configuration register at 0x535 holds 0x44. Any other value keeps all cascade inputs closed.
- R4: Line g (bank g/8, local bit g%8) is pending while irqReq[g] is high, its mask bit is 0 and its bank is free. The presented vector is 0x800 + 16*g.
- R5: When several lines are pending, the lowest global line number is presented.
- R6: intOut is high exactly while a vector is presented. The vector and intOut hold steady until a one-cycle intAck pulse takes them, even if a lower-numbered line becomes pending meanwhile.
- R7: Taking a line marks its bank busy. The bank presents nothing more until two commands have been written, in either order: 0xE0|n to its command port (0x536, 0x53A or 0x53C, with n the local line), and 0xE0|k to 0x534 (k = 1, 3 or 4 for banks 0, 1 and 2).
- R8: An end-of-interrupt that names a local line not in service has no effect, and the bank stays busy.
- R9: Writes to unmapped addresses (for example 0x533 and 0x538) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busAddr | input | 16 | I/O port address for a write or a read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (masks and configuration), 0 elsewhere |
| irqReq | input | 24 | Level-sensitive request lines, global numbering |
| intAck | input | 1 | Acknowledge pulse that takes the presented vector |
| intOut | output | 1 | Interrupt to the processor |
| vecOut | output | 12 | Presented vector, 0x800 + 16 × line |

## Verification
The bench builds the block in its only configuration: three banks of eight lines, the fixed port map and a 12-bit vector. It sweeps every one of the 24 lines through the whole cycle of unmask, present, acknowledge, block, a wrong end-of-interrupt and a correct retirement. This puts every bank, every local position and every cascade code under test. Separate passes cover the gate on the configuration value, lowest-first ranking when all lines request together, holding a vector against a newly pending lower line, and writes to unmapped addresses.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int NUM_BANKS      = 3;
  localparam int LINES_PER_BANK = 8;
  localparam int NUM_LINES      = NUM_BANKS * LINES_PER_BANK;
  localparam int LINE_W         = $clog2(NUM_LINES);
  localparam int LOCAL_W        = $clog2(LINES_PER_BANK);
  localparam int BANK_W         = $clog2(NUM_BANKS);
  localparam int ADDR_W         = 16;
  localparam int DATA_W         = 8;
  localparam int VEC_W          = 12;
  localparam int VEC_SHIFT      = 4;
  localparam logic [VEC_W-1:0]  VEC_BASE = 12'h800;

  localparam logic [ADDR_W-1:0] MASTER_CMD_ADDR = 16'h0534;
  localparam logic [ADDR_W-1:0] MASTER_CFG_ADDR = 16'h0535;
  localparam logic [DATA_W-1:0] CASCADE_ON_CODE = 8'h44;
  localparam logic [DATA_W-LOCAL_W-1:0] EOI_TAG = 5'b11100;

  function automatic logic [ADDR_W-1:0] bankCmdAddr(input int b);
    case (b)
      0:       return 16'h0536;
      1:       return 16'h053A;
      default: return 16'h053C;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] bankMaskAddr(input int b);
    return bankCmdAddr(b) + 16'd1;
  endfunction

  function automatic logic [LOCAL_W-1:0] cascadeInput(input int b);
    case (b)
      0:       return 3'd1;
      1:       return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_BANKS-1:0] maskWr;
    logic [NUM_BANKS-1:0] slaveEoi;
    logic [NUM_BANKS-1:0] masterEoi;
    logic                 cfgWr;
    logic [LOCAL_W-1:0]   eoiLine;
    logic [DATA_W-1:0]    data;
  } ctrlStrobes_t;
endpackage

// File: rtl/banked_irq_decode.sv
module banked_irq_decode
  import banked_irq_pkg::*;
(
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobes_t      strb
);
  logic isEoi;

  assign isEoi = (busWdata[DATA_W-1:LOCAL_W] == EOI_TAG);

  always_comb begin
    strb         = '0;
    strb.data    = busWdata;
    strb.eoiLine = busWdata[LOCAL_W-1:0];
    strb.cfgWr   = busWr && (busAddr == MASTER_CFG_ADDR);
    for (int b = 0; b < NUM_BANKS; b++) begin
      strb.maskWr[b]    = busWr && (busAddr == bankMaskAddr(b));
      strb.slaveEoi[b]  = busWr && isEoi && (busAddr == bankCmdAddr(b));
      strb.masterEoi[b] = busWr && isEoi && (busAddr == MASTER_CMD_ADDR) &&
                          (busWdata[LOCAL_W-1:0] == cascadeInput(b));
    end
  end
endmodule

// File: rtl/banked_irq_core.sv
module banked_irq_core
  import banked_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 intAck,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 vecValid,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 cascadeOn
);
  logic [NUM_LINES-1:0] maskReg;
  logic [NUM_LINES-1:0] slaveIsr;
  logic [NUM_BANKS-1:0] masterIsr;
  logic [DATA_W-1:0]    cfgReg;
  logic [LINE_W-1:0]    curLine;
  logic [NUM_LINES-1:0] eligible;
  logic [NUM_BANKS-1:0] bankFree;
  logic                 found;
  logic [LINE_W-1:0]    pick;
  logic [BANK_W-1:0]    curBank;

  assign cascadeOn = (cfgReg == CASCADE_ON_CODE);
  assign curBank   = curLine[LINE_W-1:LOCAL_W];
  assign vecOut    = VEC_BASE + (VEC_W'(curLine) << VEC_SHIFT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankFree[b] = ~|slaveIsr[b*LINES_PER_BANK +: LINES_PER_BANK] & ~masterIsr[b];
    assign eligible[b*LINES_PER_BANK +: LINES_PER_BANK] =
      irqReq[b*LINES_PER_BANK +: LINES_PER_BANK] &
      ~maskReg[b*LINES_PER_BANK +: LINES_PER_BANK] &
      {LINES_PER_BANK{bankFree[b] & cascadeOn}};
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        pick  = LINE_W'(i);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (busAddr == bankMaskAddr(b)) busRdata = maskReg[b*LINES_PER_BANK +: LINES_PER_BANK];
    if (busAddr == MASTER_CFG_ADDR) busRdata = cfgReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '1;
      slaveIsr  <= '0;
      masterIsr <= '0;
      cfgReg    <= '0;
      curLine   <= '0;
      vecValid  <= 1'b0;
    end else begin
      if (strb.cfgWr) cfgReg <= strb.data;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strb.maskWr[b]) maskReg[b*LINES_PER_BANK +: LINES_PER_BANK] <= strb.data;
        if (strb.slaveEoi[b]) slaveIsr[b*LINES_PER_BANK + int'(strb.eoiLine)] <= 1'b0;
        if (strb.masterEoi[b]) masterIsr[b] <= 1'b0;
      end
      if (vecValid && intAck) begin
        vecValid          <= 1'b0;
        slaveIsr[curLine] <= 1'b1;
        for (int b = 0; b < NUM_BANKS; b++)
          if (int'(curBank) == b) masterIsr[b] <= 1'b1;
      end else if (!vecValid && found) begin
        vecValid <= 1'b1;
        curLine  <= pick;
      end
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 intAck,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut
);
  ctrlStrobes_t strb;
  logic         vecValid;
  logic         cascadeOn;

  banked_irq_decode decode_i (
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .strb(strb)
  );

  banked_irq_core core_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .irqReq(irqReq),
    .intAck(intAck), .busRdata(busRdata), .vecValid(vecValid), .vecOut(vecOut),
    .cascadeOn(cascadeOn)
  );

  assign intOut = vecValid;
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk
  import banked_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqReq,
  input logic                 intAck,
  input logic                 intOut,
  input logic [VEC_W-1:0]     vecOut,
  input logic                 cascadeOn
);
  logic [VEC_W-1:0]     lineNow;
  logic [BANK_W-1:0]    vecBank;
  logic [NUM_LINES-1:0] prevReq;

  assign lineNow = (vecOut - VEC_BASE) >> VEC_SHIFT;
  assign vecBank = lineNow[LINE_W-1:LOCAL_W];

  always_ff @(posedge clk) prevReq <= irqReq;

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (vecOut[VEC_SHIFT-1:0] == '0) && (vecOut >= VEC_BASE) && (lineNow < NUM_LINES));

  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> prevReq[lineNow[LINE_W-1:0]]);

  // R3
  cascade_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> $past(cascadeOn));

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intOut && !intAck) |=> intOut && $stable(vecOut));

  // R6
  int_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intOut) |-> $past(intAck));

  // R7
  bank_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intOut) |=> ##1 (!intOut || (vecBank != $past(vecBank, 2))));
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .intAck(intAck),
  .intOut(intOut), .vecOut(vecOut), .cascadeOn(cascadeOn)
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [23:0] irqReq = '0;
  logic        intAck = 1'b0;
  logic        intOut;
  logic [11:0] vecOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqReq(irqReq), .intAck(intAck), .intOut(intOut), .vecOut(vecOut)
  );

  function automatic logic [15:0] cmdAddr(input int b);
    return (b == 0) ? 16'h0536 : (b == 1) ? 16'h053A : 16'h053C;
  endfunction
  function automatic logic [7:0] cascadeK(input int b);
    return (b == 0) ? 8'd1 : (b == 1) ? 8'd3 : 8'd4;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0; busAddr = '0;
  endtask
  task automatic ack();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask
  task automatic settle();
    repeat (3) @(negedge clk);
  endtask
  task automatic chkInt(input bit expOn, input int expLine, input string req);
    logic [11:0] expVec;
    expVec = 12'h800 + 12'(expLine * 16);
    nChecks++;
    if (intOut !== expOn || (expOn && vecOut !== expVec)) begin
      nFails++;
      $display("FAIL %s: intOut=%0b vec=%h expected intOut=%0b vec=%h", req, intOut, vecOut, expOn, expVec);
    end
  endtask
  task automatic chkRd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); busAddr = a; #1;
    nChecks++;
    if (busRdata !== exp) begin
      nFails++;
      $display("FAIL %s: read %h got %h expected %h", req, a, busRdata, exp);
    end
    busAddr = '0;
  endtask
  task automatic closeMasks();
    wr(16'h0537, 8'hFF); wr(16'h053B, 8'hFF); wr(16'h053D, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkInt(0, 0, "R1");
    chkRd(16'h0537, 8'hFF, "R1"); chkRd(16'h053B, 8'hFF, "R1");
    chkRd(16'h053D, 8'hFF, "R1"); chkRd(16'h0535, 8'h00, "R1");

    // R3 gate on configuration value
    wr(16'h0537, 8'hFE); irqReq = 24'h1; settle();
    chkInt(0, 0, "R3");
    wr(16'h0535, 8'h40); settle();
    chkInt(0, 0, "R3");
    wr(16'h0535, 8'h44); settle();
    chkInt(1, 0, "R3");
    ack(); irqReq = '0;
    wr(16'h0536, 8'hE0); wr(16'h0534, 8'hE1); settle();
    chkInt(0, 0, "R7");

    // R9 unmapped writes
    wr(16'h0538, 8'h00); wr(16'h0533, 8'h00); wr(16'h053E, 8'h00);
    chkRd(16'h0537, 8'hFE, "R9"); chkRd(16'h053B, 8'hFF, "R9");
    chkRd(16'h053D, 8'hFF, "R9"); chkRd(16'h0535, 8'h44, "R9");

    // R2 mask write and readback per bank
    for (int b = 0; b < 3; b++) begin
      wr(cmdAddr(b) + 16'd1, 8'(8'h5A + b));
      chkRd(cmdAddr(b) + 16'd1, 8'(8'h5A + b), "R2");
    end
    closeMasks();

    // Sweep over every line: R4, R7, R8
    for (int L = 0; L < 24; L++) begin
      int b, n, n2, L2;
      b = L / 8; n = L % 8; n2 = (n + 1) % 8; L2 = b * 8 + n2;
      wr(cmdAddr(b) + 16'd1, ~(8'(1) << n) & ~(8'(1) << n2));
      irqReq = 24'(1) << L; settle();
      chkInt(1, L, "R4");
      ack(); settle();
      chkInt(0, 0, "R7");
      irqReq = 24'(1) << L2; settle();
      chkInt(0, 0, "R7");
      wr(cmdAddr(b), 8'(8'hE0 | n2)); wr(16'h0534, 8'hE0 | cascadeK(b)); settle();
      chkInt(0, 0, "R8");
      wr(cmdAddr(b), 8'(8'hE0 | n)); settle();
      chkInt(1, L2, "R7");
      ack(); irqReq = '0;
      wr(16'h0534, 8'hE0 | cascadeK(b)); wr(cmdAddr(b), 8'(8'hE0 | n2)); settle();
      chkInt(0, 0, "R7");
      wr(cmdAddr(b) + 16'd1, 8'hFF);
    end

    // R5 lowest line first, banks blocked after taking
    wr(16'h0537, 8'h00); wr(16'h053B, 8'h00); wr(16'h053D, 8'h00);
    irqReq = '1; settle();
    chkInt(1, 0, "R5");
    ack(); settle(); chkInt(1, 8, "R5");
    ack(); settle(); chkInt(1, 16, "R5");
    ack(); settle(); chkInt(0, 0, "R7");
    wr(16'h053A, 8'hE0); wr(16'h0534, 8'hE3); settle();
    chkInt(1, 8, "R5");
    ack(); irqReq = '0;
    wr(16'h0536, 8'hE0); wr(16'h0534, 8'hE1);
    wr(16'h053A, 8'hE0); wr(16'h0534, 8'hE3);
    wr(16'h053C, 8'hE0); wr(16'h0534, 8'hE4); settle();
    chkInt(0, 0, "R7");
    closeMasks();

    // R6 vector held against a newly pending lower line
    wr(16'h053D, 8'hEF); irqReq = 24'(1) << 20; settle();
    chkInt(1, 20, "R6");
    wr(16'h0537, 8'hF7); irqReq = (24'(1) << 20) | (24'(1) << 3); settle();
    chkInt(1, 20, "R6");
    ack(); irqReq = 24'(1) << 3; settle();
    chkInt(1, 3, "R6");
    ack(); irqReq = '0;
    wr(16'h0536, 8'hE3); wr(16'h0534, 8'hE1);
    wr(16'h053C, 8'hE4); wr(16'h0534, 8'hE4); settle();
    chkInt(0, 0, "R6");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule